// File: doc/BRIEF.md
# JTAG Debug Data Register

This block is a vendor-defined test data register that forms the only path between a JTAG TAP controller and an on-chip debug unit. Under the TAP controller's state strobes it captures a response word, shifts serially from TDI toward TDO, and on update hands a command word to the debug unit in parallel. No other signals carry commands or data between the two sides.

The 48-bit register has two fields. The command field sits at the MSB end and holds an 8-bit opcode above 16 bits of write data. The read field is the 24 bits at the LSB end, next to TDO. Because of this layout, one 24-bit shift after a capture does two jobs at once. It delivers the whole read field on TDO and places a complete new command in the command field, so the host never shifts the full length for a combined access.

On the debug side, a parallel load port running on the core clock holds the latest response word. A shadow copy of the command field changes only on update. Each update raises a one-cycle valid pulse on TCK, and that event is carried into the core clock domain as a one-cycle pulse there.

Top module: `jtag_dbg_dr`

## Requirements
- R1: After reset, tdo, cmdOpcode, cmdWdata, cmdValidTck and cmdValidCore are all 0.
- R2: On a TCK rising edge with shDr high (and capDr low), the register moves one bit toward tdo: tdi enters bit 47 and tdo shows bit 0. A 48-bit word shifted in LSB-first comes out unchanged, LSB-first, on the next 48 shifts.
- R3: On a TCK rising edge with capDr high, bits 23:0 load the held response word and bits 47:24 keep their value.
- R4: On a TCK rising edge with updDr high and neither other strobe high, cmdOpcode takes bits 47:40 and cmdWdata takes bits 39:24. cmdValidTck is high for exactly the following TCK cycle.
- R5: cmdOpcode and cmdWdata change only on an update edge; capture, shift and idle cycles leave them unchanged.
- R6: A core clock edge with rspLoad high stores rspData as the held response. The next capture uses the most recent value loaded.
- R7: Each update produces exactly one cmdValidCore pulse, one core clock cycle long. While that pulse is high, cmdOpcode and cmdWdata show that update's command.
- R8: When several strobes are high on the same edge, capture wins over shift and shift wins over update. A losing update changes nothing and raises no valid pulse.
- R9: A capture followed by 24 shifts and an update does two things. tdo presents the captured response LSB-first. The 24 bits shifted in become the command: the last 8 bits shifted form cmdOpcode and the first 16 form cmdWdata.
- R10: On TCK edges with no strobe high, the register contents are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous active-low reset of the TCK-domain logic |
| capDr | input | 1 | TAP is in the capture state for this register |
| shDr | input | 1 | TAP is in the shift state for this register |
| updDr | input | 1 | TAP is in the update state for this register |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (register bit 0) |
| clk | input | 1 | Debug unit core clock |
| rstN | input | 1 | Asynchronous active-low reset of the core-domain logic |
| rspLoad | input | 1 | Store rspData as the held response |
| rspData | input | 24 | Response word from the debug unit |
| cmdOpcode | output | 8 | Command opcode shadow |
| cmdWdata | output | 16 | Command write-data shadow |
| cmdValidTck | output | 1 | One-TCK-cycle pulse after each update |
| cmdValidCore | output | 1 | One-core-cycle pulse per update, synchronised |

## Verification
Capture and shift can be requested on the same TCK edge, and so can shift and update. The bench provokes the first pair by raising capDr and shDr together over a known register image. The full 48 bits shifted out must show the captured response under an untouched command field, with no one-bit displacement. For the second pair, shDr and updDr are raised together, and the command outputs, cmdValidTck and the scoreboard queue must all stay unchanged.

// File: rtl/jdr_pkg.sv
package jdr_pkg;
  // strobes from control to datapath, at most one set per TCK edge
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } jdrStrobes_t;
endpackage

// File: rtl/jdr_ctrl.sv
module jdr_ctrl
  import jdr_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        capDr,
  input  logic        shDr,
  input  logic        updDr,
  output jdrStrobes_t strb,
  output logic        cmdValidTck,
  output logic        updToggle
);

  // fixed priority: capture, then shift, then update
  always_comb begin
    strb.capture = capDr;
    strb.shift   = shDr & ~capDr;
    strb.update  = updDr & ~capDr & ~shDr;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      cmdValidTck <= 1'b0;
      updToggle   <= 1'b0;
    end else begin
      cmdValidTck <= strb.update;
      if (strb.update) updToggle <= ~updToggle;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({strb.capture, strb.shift, strb.update})); // R8

endmodule

// File: rtl/jdr_datapath.sv
module jdr_datapath
  import jdr_pkg::*;
#(
  parameter int OP_W = 8,
  parameter int WD_W = 16,
  parameter int RD_W = 24
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              clk,
  input  logic              rstN,
  input  jdrStrobes_t       strb,
  input  logic              tdi,
  output logic              tdo,
  input  logic              rspLoad,
  input  logic [RD_W-1:0]   rspData,
  output logic [OP_W+WD_W-1:0] shadow
);

  localparam int CMD_W = OP_W + WD_W;
  localparam int W     = CMD_W + RD_W;

  logic [W-1:0]    sr;
  logic [RD_W-1:0] rspHold;

  // core-domain holding register for the response word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rspHold <= '0;
    else if (rspLoad) rspHold <= rspData;
  end

  // shift register: command field at the MSB end, read field at the LSB end
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)            sr <= '0;
    else if (strb.capture) sr[RD_W-1:0] <= rspHold;
    else if (strb.shift)   sr <= {tdi, sr[W-1:1]};
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)           shadow <= '0;
    else if (strb.update) shadow <= sr[W-1:RD_W];
  end

  assign tdo = sr[0];

  AST_SHIFT_MOVE: assert property (@(posedge tck) disable iff (!trstN)
    strb.shift |=> (sr[W-2:0] == $past(sr[W-1:1])) && (sr[W-1] == $past(tdi))); // R2

  AST_CAPTURE_KEEP: assert property (@(posedge tck) disable iff (!trstN)
    strb.capture |=> sr[W-1:RD_W] == $past(sr[W-1:RD_W])); // R3

  AST_SHADOW_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    !strb.update |=> $stable(shadow)); // R5

  AST_IDLE_HOLD: assert property (@(posedge tck) disable iff (!trstN)
    !(strb.capture || strb.shift) |=> $stable(sr)); // R10

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rspLoad |=> $stable(rspHold)); // R6

endmodule

// File: rtl/jdr_pulse_sync.sv
module jdr_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic togIn,
  output logic pulseOut
);

  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-1:0], togIn};
  end

  assign pulseOut = chain[STAGES] ^ chain[STAGES-1];

endmodule

// File: rtl/jtag_dbg_dr.sv
module jtag_dbg_dr #(
  parameter int OP_W        = 8,
  parameter int WD_W        = 16,
  parameter int RD_W        = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic            tck,
  input  logic            trstN,
  input  logic            capDr,
  input  logic            shDr,
  input  logic            updDr,
  input  logic            tdi,
  output logic            tdo,
  input  logic            clk,
  input  logic            rstN,
  input  logic            rspLoad,
  input  logic [RD_W-1:0] rspData,
  output logic [OP_W-1:0] cmdOpcode,
  output logic [WD_W-1:0] cmdWdata,
  output logic            cmdValidTck,
  output logic            cmdValidCore
);

  localparam int CMD_W = OP_W + WD_W;

  jdr_pkg::jdrStrobes_t strb;
  logic                 updToggle;
  logic [CMD_W-1:0]     shadow;

  jdr_ctrl u_ctrl (
    .tck(tck), .trstN(trstN), .capDr(capDr), .shDr(shDr), .updDr(updDr),
    .strb(strb), .cmdValidTck(cmdValidTck), .updToggle(updToggle)
  );

  jdr_datapath #(.OP_W(OP_W), .WD_W(WD_W), .RD_W(RD_W)) u_dp (
    .tck(tck), .trstN(trstN), .clk(clk), .rstN(rstN), .strb(strb),
    .tdi(tdi), .tdo(tdo), .rspLoad(rspLoad), .rspData(rspData),
    .shadow(shadow)
  );

  jdr_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .togIn(updToggle), .pulseOut(cmdValidCore)
  );

  assign cmdOpcode = shadow[CMD_W-1:WD_W];
  assign cmdWdata  = shadow[WD_W-1:0];

endmodule

// File: tb/sim_jtag_dbg_dr.sv
`timescale 1ns/1ps
module sim_jtag_dbg_dr;

  logic tck = 0, clk = 0, trstN = 0, rstN = 0;
  logic capDr = 0, shDr = 0, updDr = 0, tdi = 0, rspLoad = 0;
  logic [23:0] rspData = '0;
  logic tdo, cmdValidTck, cmdValidCore;
  logic [7:0]  cmdOpcode;
  logic [15:0] cmdWdata;

  int nChecks = 0, nFail = 0, nPushed = 0, nPulses = 0;
  bit done = 0;
  logic [23:0] expQ[$];

  always #10 clk = ~clk;   // 50 MHz core clock
  always #50 tck = ~tck;   // 10 MHz test clock

  jtag_dbg_dr u0 (
    .tck(tck), .trstN(trstN), .capDr(capDr), .shDr(shDr), .updDr(updDr),
    .tdi(tdi), .tdo(tdo), .clk(clk), .rstN(rstN), .rspLoad(rspLoad),
    .rspData(rspData), .cmdOpcode(cmdOpcode), .cmdWdata(cmdWdata),
    .cmdValidTck(cmdValidTck), .cmdValidCore(cmdValidCore)
  );

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one TCK cycle of strobes, driven at the falling edge
  task automatic tick(input logic c, input logic s, input logic u, input logic d);
    @(negedge tck);
    capDr = c; shDr = s; updDr = u; tdi = d;
  endtask

  task automatic shiftN(input int n, input logic [47:0] din, output logic [47:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge tck);
      dout[i] = tdo;
      capDr = 0; shDr = 1; updDr = 0; tdi = din[i];
    end
    tick(0, 0, 0, 0);
  endtask

  task automatic loadRsp(input logic [23:0] v);
    @(negedge clk);
    rspLoad = 1; rspData = v;
    @(negedge clk);
    rspLoad = 0;
  endtask

  // driver: update and push the expected command into the scoreboard
  task automatic doUpdate(input logic [23:0] expCmd);
    expQ.push_back(expCmd);
    nPushed++;
    tick(0, 0, 1, 0);
    tick(0, 0, 0, 0);
    chk(cmdValidTck === 1'b1, "R4 valid high", {47'b0, cmdValidTck}, 48'h1);
    chk({cmdOpcode, cmdWdata} === expCmd, "R4 command", {24'b0, cmdOpcode, cmdWdata}, {24'b0, expCmd});
    tick(0, 0, 0, 0);
    chk(cmdValidTck === 1'b0, "R4 valid one cycle", {47'b0, cmdValidTck}, 48'h0);
  endtask

  // monitor: pop and compare on each core-domain pulse
  always @(negedge clk) begin
    if (cmdValidCore === 1'b1) begin
      nPulses++;
      nChecks++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R7 unexpected pulse actual=%h expected=none", {cmdOpcode, cmdWdata});
      end else begin
        logic [23:0] e;
        e = expQ.pop_front();
        if ({cmdOpcode, cmdWdata} !== e) begin
          nFail++;
          $display("FAIL R7 core command actual=%h expected=%h", {cmdOpcode, cmdWdata}, e);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [47:0] o, p1, p2, p3, p4;
    logic [23:0] c9, prevCmd;
    p1 = 48'hA5C3_1E2D_F00F;
    p2 = 48'h1234_5678_9ABC;
    p3 = 48'hC7E1_0BAD_4411;
    p4 = 48'h0F1E_2D3C_4B5A;
    c9 = 24'h3C_BEEF;

    repeat (3) @(negedge tck);
    trstN = 1; rstN = 1;
    @(negedge tck);
    // R1 reset state
    chk(tdo === 1'b0, "R1 tdo", {47'b0, tdo}, 48'h0);
    chk({cmdOpcode, cmdWdata} === 24'h0, "R1 command", {24'b0, cmdOpcode, cmdWdata}, 48'h0);
    chk(cmdValidTck === 1'b0 && cmdValidCore === 1'b0, "R1 valids",
        {46'b0, cmdValidTck, cmdValidCore}, 48'h0);

    // R2 serial path
    shiftN(48, p1, o);
    chk(o === 48'h0, "R2 reset contents out", o, 48'h0);
    shiftN(48, p2, o);
    chk(o === p1, "R2 word through", o, p1);

    // R10 idle hold
    repeat (5) tick(0, 0, 0, 0);
    shiftN(48, p3, o);
    chk(o === p2, "R10 idle hold", o, p2);

    // R5 no update yet
    chk({cmdOpcode, cmdWdata} === 24'h0, "R5 shadow before update", {24'b0, cmdOpcode, cmdWdata}, 48'h0);

    // R4 update of p3
    doUpdate(p3[47:24]);

    // R6 latest response captured, R3 command field kept
    loadRsp(24'h111111);
    loadRsp(24'hABCDEF);
    repeat (2) tick(0, 0, 0, 0);
    tick(1, 0, 0, 0);
    tick(0, 0, 0, 0);
    chk({cmdOpcode, cmdWdata} === p3[47:24], "R5 shadow after capture",
        {24'b0, cmdOpcode, cmdWdata}, {24'b0, p3[47:24]});
    shiftN(48, 48'h0, o);
    chk(o[23:0] === 24'hABCDEF, "R6 latest response", {24'b0, o[23:0]}, 48'hABCDEF);
    chk(o[47:24] === p3[47:24], "R3 command field kept", {24'b0, o[47:24]}, {24'b0, p3[47:24]});
    chk({cmdOpcode, cmdWdata} === p3[47:24], "R5 shadow after shift",
        {24'b0, cmdOpcode, cmdWdata}, {24'b0, p3[47:24]});

    // R9 combined 24-bit access
    loadRsp(24'h5A0F96);
    repeat (2) tick(0, 0, 0, 0);
    tick(1, 0, 0, 0);
    shiftN(24, {24'b0, c9}, o);
    chk(o[23:0] === 24'h5A0F96, "R9 read field out", {24'b0, o[23:0]}, 48'h5A0F96);
    doUpdate(c9);
    chk(cmdOpcode === 8'h3C && cmdWdata === 16'hBEEF, "R9 command from 24 bits",
        {24'b0, cmdOpcode, cmdWdata}, 48'h3CBEEF);

    // R8 capture and shift together: capture wins
    shiftN(48, p4, o);
    loadRsp(24'h777001);
    repeat (2) tick(0, 0, 0, 0);
    tick(1, 1, 0, 1);
    tick(0, 0, 0, 0);
    shiftN(48, 48'h0, o);
    chk(o === {p4[47:24], 24'h777001}, "R8 capture over shift", o, {p4[47:24], 24'h777001});

    // R8 shift and update together: shift wins, no update
    prevCmd = {cmdOpcode, cmdWdata};
    tick(0, 1, 1, 0);
    tick(0, 0, 0, 0);
    chk(cmdValidTck === 1'b0, "R8 no valid on lost update", {47'b0, cmdValidTck}, 48'h0);
    chk({cmdOpcode, cmdWdata} === prevCmd, "R8 shadow kept", {24'b0, cmdOpcode, cmdWdata}, {24'b0, prevCmd});

    // R7 one core pulse per update
    repeat (10) tick(0, 0, 0, 0);
    chk(nPulses == nPushed, "R7 pulse count", 48'(nPulses), 48'(nPushed));
    chk(expQ.size() == 0, "R7 queue drained", 48'(expQ.size()), 48'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule